// File: doc/BRIEF.md
# Serial Configuration Register File

This block is the control-register port of a three-channel image-sensor front end. An external controller reaches it over three wires: a serial clock, an active-low load strobe and a data line. The data line is split into an input, an output and an output enable, and a pad outside the block joins them into one bidirectional pin. Eight 9-bit registers sit behind the port: one for operating mode, one for channel order and selection, three for per-channel gain and three for per-channel offset. Their contents drive the analog stages continuously through parallel outputs.

Every serial pin is sampled with the block clock. Each level of the serial clock and of the strobe must stay stable for at least two block-clock cycles. A frame opens when the strobe goes low. Thirteen bits follow on rising serial-clock edges: a direction flag, a 3-bit address and nine data bits. A write takes effect when the strobe returns high. A read returns the addressed register on the data line during the last nine bit periods, and each bit changes after a falling serial-clock edge.

Top module: `serial_cfg_regs`

## Requirements
- R1: The first bit of a frame is the direction flag (1 = read, 0 = write). The next three bits are the address, most significant first, and the last nine are the data, bit 8 first. Each bit is taken on a rising serial-clock edge seen while the strobe is low.
- R2: Addresses select registers as follows: 0 mode, 1 channel select, 2/3/4 red/green/blue gain, 5/6/7 red/green/blue offset.
- R3: A write frame with at least 13 bits updates its register at the first block-clock edge that samples the strobe high. Bits after the thirteenth are ignored.
- R4: A frame that ends with fewer than 13 counted bits changes no register. A rising serial edge sampled together with the strobe already high is not counted.
- R5: In a read frame, after the falling serial edge that follows the fourth bit, sdata_out carries register bit 8. It then steps down to bit 0, one bit on each later falling edge. A read leaves every register unchanged.
- R6: sdata_oe is high only between the first data-phase falling edge of a read frame and the release of the strobe. It is low during write frames and between frames.
- R7: A gain register keeps only data bits 5..0. Bits 8..6 always read back as 0.
- R8: An offset register keeps all nine bits, with bit 8 as the sign.
- R9: After reset the mode register is 0x038: bit 5 three-channel, bit 4 correlated sampling, bit 3 high clamp bias, bit 2 power-down off, bit 1 low input range and bit 0 output format, all at these settings. The channel-select register is 0x0C0, which is bit 7 red-first order with only bit 6 (red) set. All gain and offset registers are 0.
- R10: Writing the mode register, including setting its power-down bit 2, leaves every other register unchanged.
- R11: No register changes while the strobe is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sclk | input | 1 | Serial clock |
| load_n | input | 1 | Active-low frame strobe |
| sdata_in | input | 1 | Serial data from pad |
| sdata_out | output | 1 | Serial read data to pad |
| sdata_oe | output | 1 | Pad output enable |
| cfg_o | output | 9 | Mode register |
| mux_o | output | 9 | Channel-select register |
| gain_red | output | 6 | Red gain code |
| gain_grn | output | 6 | Green gain code |
| gain_blu | output | 6 | Blue gain code |
| offs_red | output | 9 | Red offset, sign-magnitude |
| offs_grn | output | 9 | Green offset, sign-magnitude |
| offs_blu | output | 9 | Blue offset, sign-magnitude |

## Verification
Two events can fall in the same block-clock cycle: the thirteenth rising serial edge and the release of the strobe. The bench provokes this by raising the serial clock and the strobe on the same cycle in a write frame. It expects the edge to go uncounted and the target register to keep its old value. A clean release after thirteen bits and an early release after ten bits are also driven, and their outcomes are compared with this one.

// File: rtl/serial_cfg_regs.sv
module serial_cfg_regs #(
  parameter int REG_W   = 9,
  parameter int GAIN_W  = 6,
  parameter int ADDR_W  = 3,
  parameter logic [REG_W-1:0] CFG_RST = 9'h038,
  parameter logic [REG_W-1:0] MUX_RST = 9'h0C0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sclk,
  input  logic              load_n,
  input  logic              sdata_in,
  output logic              sdata_out,
  output logic              sdata_oe,
  output logic [REG_W-1:0]  cfg_o,
  output logic [REG_W-1:0]  mux_o,
  output logic [GAIN_W-1:0] gain_red,
  output logic [GAIN_W-1:0] gain_grn,
  output logic [GAIN_W-1:0] gain_blu,
  output logic [REG_W-1:0]  offs_red,
  output logic [REG_W-1:0]  offs_grn,
  output logic [REG_W-1:0]  offs_blu
);
  localparam int NREG  = 1 << ADDR_W;
  localparam int FRAME = 1 + ADDR_W + REG_W;
  localparam int CW    = $clog2(FRAME + 1);
  localparam logic [ADDR_W-1:0] GAIN_LO = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] GAIN_HI = ADDR_W'(4);

  logic              sclk_q, load_q, sdo_q, oe_q;
  logic [CW-1:0]     cnt;
  logic [REG_W-1:0]  sh;
  logic [ADDR_W:0]   hdr;
  logic [REG_W-1:0]  regs [NREG];

  wire rise    = sclk & ~sclk_q & ~load_n;
  wire fall    = ~sclk & sclk_q & ~load_n;
  wire release_w = load_n & ~load_q;
  wire [ADDR_W-1:0] addr = hdr[ADDR_W-1:0];
  wire is_read = hdr[ADDR_W];
  wire wr_en   = release_w && (cnt == CW'(FRAME)) && !is_read;
  wire is_gain = (addr >= GAIN_LO) && (addr <= GAIN_HI);
  wire [REG_W-1:0] rd_word = regs[addr];
  wire [CW-1:0] bidx = CW'(FRAME - 1) - cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q <= 1'b0;
      load_q <= 1'b1;
      cnt    <= '0;
      sh     <= '0;
      hdr    <= '0;
      sdo_q  <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      sclk_q <= sclk;
      load_q <= load_n;
      if (load_n) begin
        cnt  <= '0;
        oe_q <= 1'b0;
      end else begin
        if (rise && cnt < CW'(FRAME)) begin
          sh  <= {sh[REG_W-2:0], sdata_in};
          cnt <= cnt + 1'b1;
          if (cnt == CW'(ADDR_W)) hdr <= {sh[ADDR_W-1:0], sdata_in};
        end
        if (fall && is_read && cnt > CW'(ADDR_W) && cnt < CW'(FRAME)) begin
          oe_q  <= 1'b1;
          sdo_q <= rd_word[bidx];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++)
        regs[i] <= (i == 0) ? CFG_RST : (i == 1) ? MUX_RST : '0;
    end else if (wr_en) begin
      regs[addr] <= is_gain ? {{(REG_W-GAIN_W){1'b0}}, sh[GAIN_W-1:0]} : sh;
    end
  end

  assign sdata_out = sdo_q;
  assign sdata_oe  = oe_q;
  assign cfg_o     = regs[0];
  assign mux_o     = regs[1];
  assign gain_red  = regs[2][GAIN_W-1:0];
  assign gain_grn  = regs[3][GAIN_W-1:0];
  assign gain_blu  = regs[4][GAIN_W-1:0];
  assign offs_red  = regs[5];
  assign offs_grn  = regs[6];
  assign offs_blu  = regs[7];

  wire [6*REG_W-1:0] others = {mux_o, regs[2], regs[3], regs[4], offs_red, offs_grn};
  wire [8*REG_W-1:0] snap   = {cfg_o, others, offs_blu};

  AST_OE_ONLY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    (load_n && $past(load_n)) |-> !sdata_oe); // R6
  AST_HOLD_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !load_n |=> $stable(snap)); // R11
  AST_SHORT_DISCARD: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(load_n) && cnt < CW'(FRAME)) |=> $stable(snap)); // R4
  AST_MODE_WRITE_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == '0) |=> ($stable(others) && $stable(offs_blu))); // R10
  AST_RESET_DEFAULT: assert property (@(posedge clk)
    $rose(rst_n) |-> (cfg_o == CFG_RST && mux_o == MUX_RST)); // R9
  AST_GAIN_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && is_read && is_gain && cnt > CW'(ADDR_W) && cnt < CW'(ADDR_W + 1 + REG_W - GAIN_W))
      |=> !sdata_out); // R7
endmodule

// File: tb/test_serial_cfg_regs.sv
module test_serial_cfg_regs;
  logic clk = 1'b0, rst_n = 1'b0, sclk = 1'b0, load_n = 1'b1, sdata_in = 1'b0;
  logic sdata_out, sdata_oe;
  logic [8:0] cfg_o, mux_o, offs_red, offs_grn, offs_blu;
  logic [5:0] gain_red, gain_grn, gain_blu;
  int checks = 0, failures = 0;
  bit done = 0;
  logic [8:0] mdl [8];

  always #10 clk = ~clk;

  serial_cfg_regs i_serial_cfg_regs (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .load_n(load_n), .sdata_in(sdata_in),
    .sdata_out(sdata_out), .sdata_oe(sdata_oe), .cfg_o(cfg_o), .mux_o(mux_o),
    .gain_red(gain_red), .gain_grn(gain_grn), .gain_blu(gain_blu),
    .offs_red(offs_red), .offs_grn(offs_grn), .offs_blu(offs_blu));

  localparam logic [20:0] VEC [8] = '{
    {3'd0, 9'h1A5, 9'h1A5}, {3'd1, 9'h0F3, 9'h0F3},
    {3'd2, 9'h1FF, 9'h03F}, {3'd3, 9'h0AA, 9'h02A},
    {3'd4, 9'h155, 9'h015}, {3'd5, 9'h100, 9'h100},
    {3'd6, 9'h0FF, 9'h0FF}, {3'd7, 9'h1FF, 9'h1FF}};

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic frame(input logic rw, input logic [2:0] a, input logic [8:0] d,
                       input int nbits, input int rel, output logic [8:0] rd, output int oebad);
    logic [12:0] fv;
    fv = {rw, a, d};
    rd = '0;
    oebad = 0;
    load_n = 1'b0;
    wclk(2);
    for (int i = 0; i < nbits; i++) begin
      sclk = 1'b0;
      sdata_in = (i < 13) ? fv[12-i] : 1'b1;
      wclk(2);
      if (i >= 4 && i < 13) rd[12-i] = sdata_out;
      if (sdata_oe !== (rw && i >= 4)) oebad++;
      sclk = 1'b1;
      if (rel == 1 && i == nbits - 1) load_n = 1'b1;
      wclk(2);
    end
    sclk = 1'b0;
    wclk(2);
    if (rel == 0) begin
      load_n = 1'b1;
      wclk(2);
    end
  endtask

  task automatic check_all(input string req);
    check(req, cfg_o, mdl[0]);
    check(req, mux_o, mdl[1]);
    check(req, {3'b0, gain_red}, mdl[2]);
    check(req, {3'b0, gain_grn}, mdl[3]);
    check(req, {3'b0, gain_blu}, mdl[4]);
    check(req, offs_red, mdl[5]);
    check(req, offs_grn, mdl[6]);
    check(req, offs_blu, mdl[7]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [8:0] rd;
    int oeb;
    mdl = '{9'h038, 9'h0C0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0, 9'h0};
    wclk(3);
    rst_n = 1'b1;
    wclk(2);
    check_all("R9 reset values");
    check("R6 oe idle", {8'b0, sdata_oe}, 9'h0);

    for (int v = 0; v < 8; v++) begin
      frame(1'b0, VEC[v][20:18], VEC[v][17:9], 13, 0, rd, oeb);
      mdl[VEC[v][20:18]] = VEC[v][8:0];
      check("R6 oe low in write", 9'(oeb), 9'h0);
      check_all("R1 R2 R3 R7 R8 write map");
      frame(1'b1, VEC[v][20:18], 9'h000, 13, 0, rd, oeb);
      check("R5 readback", rd, VEC[v][8:0]);
      check("R6 oe during read", 9'(oeb), 9'h0);
      check_all("R5 read leaves registers");
    end

    frame(1'b0, 3'd0, 9'h03C, 13, 0, rd, oeb);
    mdl[0] = 9'h03C;
    check_all("R10 power-down write isolated");

    frame(1'b0, 3'd5, 9'h0AB, 10, 0, rd, oeb);
    check_all("R4 short frame discarded");

    frame(1'b0, 3'd6, 9'h001, 13, 1, rd, oeb);
    check_all("R4 coincident release discarded");

    frame(1'b0, 3'd7, 9'h0C3, 15, 0, rd, oeb);
    mdl[7] = 9'h0C3;
    check("R3 extra bits ignored", offs_blu, 9'h0C3);

    frame(1'b0, 3'd0, 9'h111, 13, 2, rd, oeb);
    check("R11 hold while strobe low", cfg_o, mdl[0]);
    load_n = 1'b1;
    wclk(2);
    mdl[0] = 9'h111;
    check("R3 commit on release", cfg_o, 9'h111);

    frame(1'b1, 3'd3, 9'h1FF, 13, 0, rd, oeb);
    check("R7 gain top bits read zero", rd, mdl[3]);
    check("R6 oe after read", {8'b0, sdata_oe}, 9'h0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule